// File: doc/BRIEF.md
# Serial Status Flag Register

This block holds the status flags of a serial transmitter/receiver pair and lets a CPU observe and acknowledge them over a simple register bus. The transmit and receive datapaths report events as one-cycle pulses: a transmit buffer transfer, a transmit completion, and a finished received frame with its error indications and multiprocessor bit. The block turns these events into sticky flags and owns the receive data holding register. That register is only written when the previous byte has been acknowledged. When it has not, the block raises an overrun flag instead.

The CPU reads the flag byte at any time. It acknowledges a flag by first reading it while it is 1 and then writing 0 to that bit. A write without such a read clears nothing, and a write of 1 never sets anything. Each acknowledgeable flag has its own read-while-set latch. A CPU read arms the latch, and the next write to the register consumes it, whatever value that write carries. A hardware set event always wins over a CPU clear of the same flag in the same cycle. Both the asynchronous reset and a synchronous standby input return the register to 0x84.

Top module: `ser_status_flags`

## Requirements
- R1: Reset, and standby on any clock edge, set the flag byte to 0x84 (bit 7 transmit-empty = 1, bit 2 transmit-end = 1, all other bits 0) and the receive data output to 0.
- R2: A write with a 1 in bit 7 (transmit-empty), bit 6 (receive-full), bit 5 (overrun), bit 4 (framing error) or bit 3 (parity error) never sets that flag.
- R3: A write of 0 to one of bits 7..3 leaves the flag unchanged unless a read after the previous write saw that flag at 1.
- R4: A read that sees bit 7..3 at 1, followed by a write with 0 in that bit, clears the flag on that write. Any write consumes all armed latches.
- R5: Bit 2 (transmit-end) and bit 0 (multiprocessor bit) ignore CPU writes, and bit 1 always reads 0.
- R6: Bit 7 is set in the cycle after a transmit buffer transfer pulse, and while the transmitter enable input is low.
- R7: A finished frame with no error while bit 6 is 0 sets bit 6 and loads the receive data output with the frame.
- R8: A finished frame with a parity error sets bit 3, with a framing error sets bit 4, and leaves bit 6 and the receive data output unchanged.
- R9: A finished frame while bit 6 is 1 sets bit 5 (overrun), and the frame is discarded, so the receive data output keeps its value.
- R10: When a hardware set event and a CPU clear of the same flag fall in one cycle, the flag ends at 1.
- R11: Bit 0 takes the frame's multiprocessor bit on every finished frame, with or without errors.
- R12: Bit 2 is set by a transmit-end pulse and cleared by a transmit-end clear pulse. If both arrive together, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Synchronous return to the initial flag state |
| txEnable | input | 1 | Transmitter enable level; while low, bit 7 is forced to 1 |
| txLoad | input | 1 | Pulse: transmit buffer moved into the shift register |
| txEndSet | input | 1 | Pulse: transmission finished |
| txEndClr | input | 1 | Pulse: new transmission started |
| rxDone | input | 1 | Pulse: a received frame is complete |
| rxFrame | input | RX_DATA_W | Data of the completed frame |
| rxMpb | input | 1 | Multiprocessor bit of the completed frame |
| rxParityErr | input | 1 | Parity error on the completed frame |
| rxFramingErr | input | 1 | Framing error on the completed frame |
| busRd | input | 1 | CPU read strobe for the flag byte |
| busWr | input | 1 | CPU write strobe for the flag byte |
| busWdata | input | 8 | CPU write data |
| statusOut | output | 8 | Current flag byte |
| rxDataOut | output | RX_DATA_W | Receive data holding register |

## Verification
Every result is a register output, so the effect of an event or bus access sampled at a rising edge shows on `statusOut` and `rxDataOut` right after that edge. The only exception is an armed latch, which shows its effect one write later. The bench drives inputs at the falling edge, lets exactly one rising edge pass, and compares at the next falling edge. Read-then-clear sequences therefore span two such steps, and every vector's expected byte accounts for that.

// File: rtl/ser_status_pkg.sv
`timescale 1ns/1ps
package ser_status_pkg;
  localparam int STAT_W   = 8;
  localparam int TDRE_BIT = 7;
  localparam int RDRF_BIT = 6;
  localparam int OVR_BIT  = 5;
  localparam int FER_BIT  = 4;
  localparam int PER_BIT  = 3;
  localparam int TEND_BIT = 2;
  localparam int MPB_BIT  = 0;
  localparam logic [STAT_W-1:0] INIT_VALUE    = 8'h84;
  // flags that use the read-then-write-zero acknowledge
  localparam logic [STAT_W-1:0] ACK_MASK      = 8'hF8;
  // flags driven by set/clear events (acknowledgeable plus transmit-end)
  localparam logic [STAT_W-1:0] EVENT_MASK    = 8'hFC;

  typedef struct packed {
    logic [STAT_W-1:0] setVec;
    logic [STAT_W-1:0] clrVec;
    logic              loadRdr;
    logic              loadMpb;
  } flagStrobes_t;
endpackage

// File: rtl/ser_status_ctrl.sv
`timescale 1ns/1ps
module ser_status_ctrl
  import ser_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic              txEnable,
  input  logic              txLoad,
  input  logic              txEndSet,
  input  logic              txEndClr,
  input  logic              rxDone,
  input  logic              rxParityErr,
  input  logic              rxFramingErr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [STAT_W-1:0] busWdata,
  input  logic [STAT_W-1:0] flagsIn,
  output flagStrobes_t      strobes
);
  logic [STAT_W-1:0] armedQ;
  logic [STAT_W-1:0] armedNext;
  logic              rxErr;

  assign rxErr = rxParityErr | rxFramingErr;

  // read-while-set latches, one per acknowledgeable flag
  always_comb begin
    if (busWr)
      armedNext = '0;
    else if (busRd)
      armedNext = (armedQ | flagsIn) & flagsIn & ACK_MASK;
    else
      armedNext = armedQ & flagsIn & ACK_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        armedQ <= '0;
    else if (standby) armedQ <= '0;
    else              armedQ <= armedNext;
  end

  always_comb begin
    strobes = '0;
    strobes.setVec[TDRE_BIT] = ~txEnable | txLoad;
    strobes.setVec[RDRF_BIT] = rxDone & ~rxErr & ~flagsIn[RDRF_BIT];
    strobes.setVec[OVR_BIT]  = rxDone & flagsIn[RDRF_BIT];
    strobes.setVec[FER_BIT]  = rxDone & rxFramingErr;
    strobes.setVec[PER_BIT]  = rxDone & rxParityErr;
    strobes.setVec[TEND_BIT] = txEndSet;
    strobes.clrVec           = {STAT_W{busWr}} & armedQ & ~busWdata & ACK_MASK;
    strobes.clrVec[TEND_BIT] = txEndClr;
    strobes.loadRdr          = rxDone & ~rxErr & ~flagsIn[RDRF_BIT];
    strobes.loadMpb          = rxDone;
  end

  // R3: an unarmed flag survives a write
  assert_no_clear_unarmed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !armedQ[RDRF_BIT] && !standby) |=> !$fell(flagsIn[RDRF_BIT]));

  // R10: a set event leaves the flag at 1 even against a clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setVec[TDRE_BIT] && !standby) |=> flagsIn[TDRE_BIT]);

  // R5: transmit-end ignores CPU writes
  assert_tend_readonly_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !txEndSet && !txEndClr && !standby) |=> $stable(flagsIn[TEND_BIT]));

  // R2: a write never raises an acknowledgeable flag
  assert_write_one_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !rxDone && !txLoad && txEnable && !standby) |=> !$rose(flagsIn[OVR_BIT]));
endmodule

// File: rtl/ser_status_data.sv
`timescale 1ns/1ps
module ser_status_data
  import ser_status_pkg::*;
#(
  parameter int RX_DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 standby,
  input  flagStrobes_t         strobes,
  input  logic [RX_DATA_W-1:0] rxFrame,
  input  logic                 rxMpb,
  output logic [STAT_W-1:0]    flagsQ,
  output logic [RX_DATA_W-1:0] rdrQ
);
  logic [STAT_W-1:0] flagsNext;

  always_comb begin
    flagsNext = flagsQ & ~(strobes.clrVec & EVENT_MASK);
    flagsNext = flagsNext | (strobes.setVec & EVENT_MASK);
    flagsNext[MPB_BIT] = strobes.loadMpb ? rxMpb : flagsQ[MPB_BIT];
    flagsNext[1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= INIT_VALUE;
      rdrQ   <= '0;
    end else if (standby) begin
      flagsQ <= INIT_VALUE;
      rdrQ   <= '0;
    end else begin
      flagsQ <= flagsNext;
      if (strobes.loadRdr) rdrQ <= rxFrame;
    end
  end

  // R1: standby returns the initial value
  assert_standby_init_R1: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (flagsQ == INIT_VALUE));

  // R9: the holding register is never loaded while the previous byte is unacknowledged
  assert_overrun_protects_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRdr |-> !flagsQ[RDRF_BIT]);

  // R7: a load always raises receive-full
  assert_load_sets_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadRdr && !standby) |=> flagsQ[RDRF_BIT]);
endmodule

// File: rtl/ser_status_flags.sv
`timescale 1ns/1ps
module ser_status_flags
  import ser_status_pkg::*;
#(
  parameter int RX_DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 standby,
  input  logic                 txEnable,
  input  logic                 txLoad,
  input  logic                 txEndSet,
  input  logic                 txEndClr,
  input  logic                 rxDone,
  input  logic [RX_DATA_W-1:0] rxFrame,
  input  logic                 rxMpb,
  input  logic                 rxParityErr,
  input  logic                 rxFramingErr,
  input  logic                 busRd,
  input  logic                 busWr,
  input  logic [7:0]           busWdata,
  output logic [7:0]           statusOut,
  output logic [RX_DATA_W-1:0] rxDataOut
);
  flagStrobes_t      strobes;
  logic [STAT_W-1:0] flags;

  ser_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .standby(standby),
    .txEnable(txEnable), .txLoad(txLoad), .txEndSet(txEndSet), .txEndClr(txEndClr),
    .rxDone(rxDone), .rxParityErr(rxParityErr), .rxFramingErr(rxFramingErr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .flagsIn(flags), .strobes(strobes)
  );

  ser_status_data #(.RX_DATA_W(RX_DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .standby(standby), .strobes(strobes),
    .rxFrame(rxFrame), .rxMpb(rxMpb), .flagsQ(flags), .rdrQ(rxDataOut)
  );

  assign statusOut = flags;
endmodule

// File: tb/test_ser_status_flags.sv
`timescale 1ns/1ps
module test_ser_status_flags;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standby = 0, txEnable = 1, txLoad = 0, txEndSet = 0, txEndClr = 0;
  logic rxDone = 0, rxMpb = 0, rxParityErr = 0, rxFramingErr = 0;
  logic busRd = 0, busWr = 0;
  logic [7:0] rxFrame = 0, busWdata = 0, statusOut, rxDataOut;
  int vecCount = 0, missCount = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ser_status_flags i_ser_status_flags (.*);

  // op codes
  localparam logic [3:0] OP_IDLE = 0, OP_RD = 1, OP_WR = 2, OP_RXOK = 3, OP_RXPE = 4,
                         OP_RXFE = 5, OP_TXLD = 6, OP_TEND = 7, OP_TCLR = 8, OP_TXOFF = 9;
  // {op, mpb, data, expected status, expected rx data}
  localparam int NV = 21;
  localparam logic [28:0] VEC [NV] = '{
    {OP_WR,   1'b0, 8'hFF, 8'h84, 8'h00}, // R2
    {OP_WR,   1'b0, 8'h00, 8'h84, 8'h00}, // R3
    {OP_RD,   1'b0, 8'h00, 8'h84, 8'h00},
    {OP_WR,   1'b0, 8'h00, 8'h04, 8'h00}, // R4 R5
    {OP_TXLD, 1'b0, 8'h00, 8'h84, 8'h00}, // R6
    {OP_RXOK, 1'b1, 8'hA5, 8'hC5, 8'hA5}, // R7 R11
    {OP_RXOK, 1'b0, 8'h3C, 8'hE4, 8'hA5}, // R9
    {OP_RXPE, 1'b0, 8'h11, 8'hEC, 8'hA5}, // R8
    {OP_RXFE, 1'b0, 8'h22, 8'hFC, 8'hA5}, // R8
    {OP_RD,   1'b0, 8'h00, 8'hFC, 8'hA5},
    {OP_WR,   1'b0, 8'h00, 8'h04, 8'hA5}, // R4
    {OP_RXPE, 1'b1, 8'h55, 8'h0D, 8'hA5}, // R8 R11
    {OP_WR,   1'b0, 8'h00, 8'h0D, 8'hA5}, // R3
    {OP_TCLR, 1'b0, 8'h00, 8'h09, 8'hA5}, // R12
    {OP_TEND, 1'b0, 8'h00, 8'h0D, 8'hA5}, // R12
    {OP_WR,   1'b0, 8'hFF, 8'h0D, 8'hA5}, // R2 R5
    {OP_RD,   1'b0, 8'h00, 8'h0D, 8'hA5},
    {OP_IDLE, 1'b0, 8'h00, 8'h0D, 8'hA5},
    {OP_WR,   1'b0, 8'hF7, 8'h05, 8'hA5}, // R4 R5
    {OP_RXOK, 1'b0, 8'h77, 8'h44, 8'h77}, // R7
    {OP_TXOFF,1'b0, 8'h00, 8'hC4, 8'h77}  // R6
  };

  task automatic clearIn();
    txEnable = 1; txLoad = 0; txEndSet = 0; txEndClr = 0; rxDone = 0; rxMpb = 0;
    rxParityErr = 0; rxFramingErr = 0; busRd = 0; busWr = 0; busWdata = 0;
    rxFrame = 0; standby = 0;
  endtask

  task automatic stepEdge();
    @(posedge clk);
    @(negedge clk);
    clearIn();
  endtask

  task automatic check(string req, logic [7:0] expStat, logic [7:0] expRx);
    vecCount++;
    if (statusOut !== expStat || rxDataOut !== expRx) begin
      missCount++;
      $display("FAIL %s: status %h rx %h, expected status %h rx %h",
               req, statusOut, rxDataOut, expStat, expRx);
    end
  endtask

  task automatic applyOp(logic [3:0] op, logic mpb, logic [7:0] data);
    case (op)
      OP_RD:    busRd = 1;
      OP_WR:    begin busWr = 1; busWdata = data; end
      OP_RXOK:  begin rxDone = 1; rxFrame = data; rxMpb = mpb; end
      OP_RXPE:  begin rxDone = 1; rxFrame = data; rxMpb = mpb; rxParityErr = 1; end
      OP_RXFE:  begin rxDone = 1; rxFrame = data; rxMpb = mpb; rxFramingErr = 1; end
      OP_TXLD:  txLoad = 1;
      OP_TEND:  txEndSet = 1;
      OP_TCLR:  txEndClr = 1;
      OP_TXOFF: txEnable = 0;
      default:  ;
    endcase
    stepEdge();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 8'h84, 8'h00);
    rstN = 1;
    @(negedge clk);
    check("R1 after release", 8'h84, 8'h00);

    for (int i = 0; i < NV; i++) begin
      applyOp(VEC[i][28:25], VEC[i][24], VEC[i][23:16]);
      check($sformatf("R2-R12 vector %0d", i), VEC[i][15:8], VEC[i][7:0]);
    end

    // R1: standby returns to initial state
    standby = 1;
    stepEdge();
    check("R1 standby", 8'h84, 8'h00);

    // R10: transmit-empty armed, clear and transfer in the same cycle
    applyOp(OP_RD, 0, 0);
    busWr = 1; busWdata = 8'h00; txLoad = 1;
    stepEdge();
    check("R10 set beats clear", 8'h84, 8'h00);

    // R12: transmit-end set and clear together
    applyOp(OP_TCLR, 0, 0);
    check("R12 tend clear", 8'h80, 8'h00);
    txEndSet = 1; txEndClr = 1;
    stepEdge();
    check("R12 tend set wins", 8'h84, 8'h00);

    // R3: latch consumed by a write of 1, later write of 0 does nothing
    applyOp(OP_RD, 0, 0);
    applyOp(OP_WR, 0, 8'hFF);
    applyOp(OP_WR, 0, 8'h00);
    check("R3 latch consumed", 8'h84, 8'h00);

    // R9: overrun while full, data kept
    applyOp(OP_RXOK, 0, 8'h5A);
    applyOp(OP_RXOK, 1, 8'hC3);
    check("R9 overrun", 8'hE5, 8'h5A);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      missCount++;
      $display("FAIL watchdog: status %h, expected completion", statusOut);
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end
endmodule